// File: doc/BRIEF.md
# Four-Way Round-Robin Bus Arbiter with Shared-Bus Multiplexer

This block sits between four bus masters and a single shared slave-side address/control path. Each master presents a request line, a lock line and its own address, direction, size, burst, transfer-type and write-data signals. The block picks exactly one owner, reports it as a one-hot grant vector and as an index, and steers the owner's signals onto the shared bus. Write data is steered with a one-transfer delay so that it lines up with the data phase that follows each address phase.

Ownership is handed out round-robin so a requesting master is never starved. A master that wins the bus with its lock line high keeps the bus for as long as it holds that line, overriding the rotation. When nobody asks for the bus, the grant rests on master 0 and the shared transfer type is forced to idle. Every new grant is accompanied by a one-cycle strobe carrying the number of cycles the winner waited, which lets a system monitor arbitration latency without extra hardware at the masters.

Top module: `bus_arbiter_mux`

## Requirements
- R1: Exactly one bit of `grant_o` is high in every cycle, and that bit is the one whose position equals `owner_o`.
- R2: The owner, the rotation pointer and the lock hold change only on a rising edge at which `hready_i` is high; with `hready_i` low the owner is frozen.
- R3: At a ready edge with no active lock hold and at least one request, the new owner is the first requesting master found by searching upward from the rotation pointer and wrapping past master 3; the pointer then becomes (winner + 1) mod 4.
- R4: A master that was granted while its `lock_i` bit was high keeps the bus at every following ready edge while that bit stays high, even if others request, and no latency strobe is produced; when the bit drops, the rotation of R3 resumes.
- R5: At a ready edge with no request and no active lock hold, the grant moves to master 0 and `s_trans_o` is 2'b00 (idle) until a master is granted again; parking produces no strobe.
- R6: While a master owns the bus after a request, `s_addr_o`, `s_write_o`, `s_size_o`, `s_burst_o` and `s_trans_o` equal that master's inputs in the same cycle; master i's fields occupy slice [i*W +: W] of each flat input.
- R7: `s_wdata_o` equals the write data of the master that was owner at the most recent ready edge (the owner one accepted transfer earlier).
- R8: `lat_valid_o` is high for exactly the cycle in which a grant first appears for a master that was not already the requested owner (another owner, or the parked state); in that cycle `lat_master_o` equals the new owner and `lat_value_o` equals the number of rising edges at which that master's request was sampled high while it did not own the bus, counting the granting edge (an immediate grant reports 1).
- R9: The reported latency saturates at 255 and does not wrap for longer waits.
- R10: Reset is synchronous and active low: after a reset edge the grant parks on master 0 with idle transfer type, no strobe, the pointer at master 0, all wait counts zero and no lock hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| req_i | input | 4 | Bus request, one bit per master |
| lock_i | input | 4 | Lock request, one bit per master |
| hready_i | input | 1 | Shared ready; arbitration advances only when high |
| m_addr_i | input | 128 | Master addresses, 32 bits each |
| m_write_i | input | 4 | Master write direction flags |
| m_size_i | input | 12 | Master transfer sizes, 3 bits each |
| m_burst_i | input | 12 | Master burst types, 3 bits each |
| m_trans_i | input | 8 | Master transfer types, 2 bits each |
| m_wdata_i | input | 128 | Master write data, 32 bits each |
| grant_o | output | 4 | One-hot grant |
| owner_o | output | 2 | Index of the current owner |
| s_addr_o | output | 32 | Shared address |
| s_write_o | output | 1 | Shared write flag |
| s_size_o | output | 3 | Shared transfer size |
| s_burst_o | output | 3 | Shared burst type |
| s_trans_o | output | 2 | Shared transfer type, idle when parked |
| s_wdata_o | output | 32 | Shared write data, one transfer behind the address |
| lat_valid_o | output | 1 | One-cycle strobe on each new grant |
| lat_value_o | output | 8 | Cycles the new owner waited, saturating |
| lat_master_o | output | 2 | Index of the master the strobe refers to |

## Verification
The bench drives all four masters at once so the pointer has to wrap past master 3, and a rotation that restarted at master 0 or skipped the just-served master would show the wrong owner. It stretches ready low in the middle of contention, where a design that arbitrated regardless of ready would move the owner mid-transfer and misalign write data. It holds a lock while the others queue for over 255 cycles, catching both a lock that leaks to rotation and a wait counter that wraps to a small value. Back-to-back regrants of the only requester and returns from the parked state target a strobe that fires on every regrant or never after parking.

// File: rtl/bam_pkg.sv
package bam_pkg;
    localparam int SIZE_W  = 3;
    localparam int BURST_W = 3;
    localparam int TRANS_W = 2;

    typedef enum logic [TRANS_W-1:0] {
        TR_IDLE   = 2'b00,
        TR_BUSY   = 2'b01,
        TR_NONSEQ = 2'b10,
        TR_SEQ    = 2'b11
    } trans_e;
endpackage

// File: rtl/bam_rr_pick.sv
module bam_rr_pick #(
    parameter int N     = 4,
    parameter int IDX_W = $clog2(N)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N-1:0]     req_i,
    input  logic [IDX_W-1:0] ptr_i,
    output logic             any_o,
    output logic [IDX_W-1:0] pick_o
);
    logic found;

    always_comb begin
        any_o  = |req_i;
        pick_o = '0;
        found  = 1'b0;
        for (int k = 0; k < N; k++) begin
            int c;
            c = int'(ptr_i) + k;
            if (c >= N) c = c - N;
            if (!found && req_i[c]) begin
                pick_o = IDX_W'(c);
                found  = 1'b1;
            end
        end
    end

    AST_PICK_REQUESTER: assert property (@(posedge clk) disable iff (!rst_n)
        any_o |-> req_i[pick_o]) else $error("picked master has no request"); // R3
endmodule

// File: rtl/bam_wait_ctr.sv
module bam_wait_ctr #(
    parameter int N     = 4,
    parameter int LAT_W = 8,
    parameter int IDX_W = $clog2(N)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N-1:0]     req_i,
    input  logic             own_active_i,
    input  logic [IDX_W-1:0] own_idx_i,
    input  logic             win_i,
    input  logic [IDX_W-1:0] win_idx_i,
    output logic [LAT_W-1:0] win_lat_o
);
    logic [LAT_W-1:0] cnt_q [N];

    for (genvar i = 0; i < N; i++) begin : g_ctr
        logic [LAT_W-1:0] cnt_d;
        logic             owning;

        always_comb begin
            owning = own_active_i && (own_idx_i == IDX_W'(i));
            cnt_d  = '0;
            if (win_i && (win_idx_i == IDX_W'(i))) begin
                cnt_d = '0;
            end else if (req_i[i] && !owning) begin
                cnt_d = (cnt_q[i] == '1) ? cnt_q[i] : cnt_q[i] + 1'b1;
            end
        end

        always_ff @(posedge clk) begin
            if (!rst_n) cnt_q[i] <= '0;
            else        cnt_q[i] <= cnt_d;
        end

        AST_WAIT_SAT: assert property (@(posedge clk) disable iff (!rst_n)
            (cnt_q[i] == '1 && req_i[i] && !owning && !(win_i && win_idx_i == IDX_W'(i)))
            |=> cnt_q[i] == '1) else $error("wait counter wrapped"); // R9
    end

    always_comb begin
        win_lat_o = (cnt_q[win_idx_i] == '1) ? cnt_q[win_idx_i] : cnt_q[win_idx_i] + 1'b1;
    end
endmodule

// File: rtl/bam_route.sv
module bam_route
    import bam_pkg::*;
#(
    parameter int N      = 4,
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int IDX_W  = $clog2(N)
) (
    input  logic [N*ADDR_W-1:0]  m_addr_i,
    input  logic [N-1:0]         m_write_i,
    input  logic [N*SIZE_W-1:0]  m_size_i,
    input  logic [N*BURST_W-1:0] m_burst_i,
    input  logic [N*TRANS_W-1:0] m_trans_i,
    input  logic [N*DATA_W-1:0]  m_wdata_i,
    input  logic [IDX_W-1:0]     owner_i,
    input  logic                 active_i,
    input  logic [IDX_W-1:0]     downer_i,
    output logic [ADDR_W-1:0]    s_addr_o,
    output logic                 s_write_o,
    output logic [SIZE_W-1:0]    s_size_o,
    output logic [BURST_W-1:0]   s_burst_o,
    output logic [TRANS_W-1:0]   s_trans_o,
    output logic [DATA_W-1:0]    s_wdata_o
);
    logic [ADDR_W-1:0]  addr_a  [N];
    logic [SIZE_W-1:0]  size_a  [N];
    logic [BURST_W-1:0] burst_a [N];
    logic [TRANS_W-1:0] trans_a [N];
    logic [DATA_W-1:0]  wdata_a [N];

    for (genvar i = 0; i < N; i++) begin : g_unpack
        assign addr_a[i]  = m_addr_i [i*ADDR_W  +: ADDR_W];
        assign size_a[i]  = m_size_i [i*SIZE_W  +: SIZE_W];
        assign burst_a[i] = m_burst_i[i*BURST_W +: BURST_W];
        assign trans_a[i] = m_trans_i[i*TRANS_W +: TRANS_W];
        assign wdata_a[i] = m_wdata_i[i*DATA_W  +: DATA_W];
    end

    always_comb begin
        s_addr_o  = addr_a[owner_i];
        s_write_o = m_write_i[owner_i];
        s_size_o  = size_a[owner_i];
        s_burst_o = burst_a[owner_i];
        s_trans_o = active_i ? trans_a[owner_i] : TR_IDLE;
        s_wdata_o = wdata_a[downer_i];
    end
endmodule

// File: rtl/bus_arbiter_mux.sv
module bus_arbiter_mux
    import bam_pkg::*;
#(
    parameter int N      = 4,
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int LAT_W  = 8
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic [N-1:0]                   req_i,
    input  logic [N-1:0]                   lock_i,
    input  logic                           hready_i,
    input  logic [N*ADDR_W-1:0]            m_addr_i,
    input  logic [N-1:0]                   m_write_i,
    input  logic [N*bam_pkg::SIZE_W-1:0]   m_size_i,
    input  logic [N*bam_pkg::BURST_W-1:0]  m_burst_i,
    input  logic [N*bam_pkg::TRANS_W-1:0]  m_trans_i,
    input  logic [N*DATA_W-1:0]            m_wdata_i,
    output logic [N-1:0]                   grant_o,
    output logic [$clog2(N)-1:0]           owner_o,
    output logic [ADDR_W-1:0]              s_addr_o,
    output logic                           s_write_o,
    output logic [bam_pkg::SIZE_W-1:0]     s_size_o,
    output logic [bam_pkg::BURST_W-1:0]    s_burst_o,
    output logic [bam_pkg::TRANS_W-1:0]    s_trans_o,
    output logic [DATA_W-1:0]              s_wdata_o,
    output logic                           lat_valid_o,
    output logic [LAT_W-1:0]               lat_value_o,
    output logic [$clog2(N)-1:0]           lat_master_o
);
    localparam int IDX_W = $clog2(N);

    typedef struct packed {
        logic [IDX_W-1:0] owner;
        logic [IDX_W-1:0] ptr;
        logic             active;
        logic             hold;
        logic [IDX_W-1:0] downer;
        logic             lat_v;
        logic [LAT_W-1:0] lat_val;
        logic [IDX_W-1:0] lat_idx;
    } state_t;

    state_t           st_d, st_q;
    logic             any_req;
    logic [IDX_W-1:0] pick;
    logic             new_grant;
    logic [LAT_W-1:0] win_lat;
    logic             keep;

    bam_rr_pick #(.N(N), .IDX_W(IDX_W)) i_pick (
        .clk    (clk),
        .rst_n  (rst_n),
        .req_i  (req_i),
        .ptr_i  (st_q.ptr),
        .any_o  (any_req),
        .pick_o (pick)
    );

    bam_wait_ctr #(.N(N), .LAT_W(LAT_W), .IDX_W(IDX_W)) i_wait (
        .clk          (clk),
        .rst_n        (rst_n),
        .req_i        (req_i),
        .own_active_i (st_q.active),
        .own_idx_i    (st_q.owner),
        .win_i        (new_grant),
        .win_idx_i    (pick),
        .win_lat_o    (win_lat)
    );

    always_comb begin
        st_d      = st_q;
        st_d.lat_v = 1'b0;
        new_grant = 1'b0;
        keep      = st_q.hold && lock_i[st_q.owner];
        if (hready_i) begin
            st_d.downer = st_q.owner;
            if (keep) begin
                st_d.owner = st_q.owner;
            end else if (any_req) begin
                st_d.owner  = pick;
                st_d.active = 1'b1;
                st_d.hold   = lock_i[pick];
                st_d.ptr    = IDX_W'((int'(pick) + 1) % N);
                if (!st_q.active || pick != st_q.owner) begin
                    new_grant    = 1'b1;
                    st_d.lat_v   = 1'b1;
                    st_d.lat_val = win_lat;
                    st_d.lat_idx = pick;
                end
            end else begin
                st_d.owner  = '0;
                st_d.active = 1'b0;
                st_d.hold   = 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    bam_route #(.N(N), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .IDX_W(IDX_W)) i_route (
        .m_addr_i  (m_addr_i),
        .m_write_i (m_write_i),
        .m_size_i  (m_size_i),
        .m_burst_i (m_burst_i),
        .m_trans_i (m_trans_i),
        .m_wdata_i (m_wdata_i),
        .owner_i   (st_q.owner),
        .active_i  (st_q.active),
        .downer_i  (st_q.downer),
        .s_addr_o  (s_addr_o),
        .s_write_o (s_write_o),
        .s_size_o  (s_size_o),
        .s_burst_o (s_burst_o),
        .s_trans_o (s_trans_o),
        .s_wdata_o (s_wdata_o)
    );

    always_comb begin
        grant_o      = '0;
        grant_o[st_q.owner] = 1'b1;
        owner_o      = st_q.owner;
        lat_valid_o  = st_q.lat_v;
        lat_value_o  = st_q.lat_val;
        lat_master_o = st_q.lat_idx;
    end

    AST_ONE_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(grant_o) == 1) else $error("grant not one-hot"); // R1

    AST_FROZEN_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
        !hready_i |=> $stable(owner_o)) else $error("owner moved without ready"); // R2

    AST_RR_WINNER: assert property (@(posedge clk) disable iff (!rst_n)
        (hready_i && !keep && any_req) |=> |($past(req_i) & grant_o))
        else $error("winner was not requesting"); // R3

    AST_LOCK_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (hready_i && keep) |=> ($stable(owner_o) && !lat_valid_o))
        else $error("locked owner lost the bus"); // R4

    AST_PARK_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (hready_i && !keep && req_i == '0) |=> (owner_o == '0 && s_trans_o == TR_IDLE))
        else $error("idle bus not parked"); // R5

    AST_STROBE_OWNER: assert property (@(posedge clk) disable iff (!rst_n)
        lat_valid_o |-> (lat_value_o != '0 && lat_master_o == owner_o))
        else $error("latency strobe inconsistent"); // R8
endmodule

// File: tb/test_bus_arbiter_mux.sv
module test_bus_arbiter_mux;
    localparam int CLK_PERIOD = 10;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [3:0]   req = '0, lock = '0;
    logic         hready = 1'b1;
    logic [31:0]  maddr [4];
    logic [31:0]  mwdata[4];
    logic         mwrite[4];
    logic [2:0]   msize [4];
    logic [2:0]   mburst[4];
    logic [1:0]   mtrans[4];

    logic [127:0] m_addr, m_wdata;
    logic [3:0]   m_write;
    logic [11:0]  m_size, m_burst;
    logic [7:0]   m_trans;

    logic [3:0]   grant_o;
    logic [1:0]   owner_o, lat_master_o;
    logic [31:0]  s_addr_o, s_wdata_o;
    logic         s_write_o, lat_valid_o;
    logic [2:0]   s_size_o, s_burst_o;
    logic [1:0]   s_trans_o;
    logic [7:0]   lat_value_o;

    int errors = 0;
    int checks = 0;
    int cyc = 0;

    // reference model state
    int  r_owner = 0, r_ptr = 0, r_downer = 0;
    bit  r_active = 0, r_hold = 0, r_latv = 0;
    int  r_latval = 0, r_latidx = 0;
    int  r_wait[4] = '{0, 0, 0, 0};
    bit  r_prev_ready = 1, r_prev_keep = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    always_comb begin
        for (int i = 0; i < 4; i++) begin
            m_addr [i*32 +: 32] = maddr[i];
            m_wdata[i*32 +: 32] = mwdata[i];
            m_write[i]          = mwrite[i];
            m_size [i*3 +: 3]   = msize[i];
            m_burst[i*3 +: 3]   = mburst[i];
            m_trans[i*2 +: 2]   = mtrans[i];
        end
    end

    bus_arbiter_mux i_bus_arbiter_mux (
        .clk(clk), .rst_n(rst_n), .req_i(req), .lock_i(lock), .hready_i(hready),
        .m_addr_i(m_addr), .m_write_i(m_write), .m_size_i(m_size), .m_burst_i(m_burst),
        .m_trans_i(m_trans), .m_wdata_i(m_wdata),
        .grant_o(grant_o), .owner_o(owner_o), .s_addr_o(s_addr_o), .s_write_o(s_write_o),
        .s_size_o(s_size_o), .s_burst_o(s_burst_o), .s_trans_o(s_trans_o), .s_wdata_o(s_wdata_o),
        .lat_valid_o(lat_valid_o), .lat_value_o(lat_value_o), .lat_master_o(lat_master_o)
    );

    // behavioural model, advanced on the same edges as the design
    always @(posedge clk) begin
        int  old_owner, win;
        bit  old_active, newg, keep;
        old_owner  = r_owner;
        old_active = r_active;
        newg = 0; win = 0;
        keep = r_hold && lock[r_owner];
        if (!rst_n) begin
            r_owner = 0; r_ptr = 0; r_downer = 0; r_active = 0; r_hold = 0;
            r_latv = 0; r_latval = 0; r_latidx = 0;
            for (int i = 0; i < 4; i++) r_wait[i] = 0;
            r_prev_ready = 1; r_prev_keep = 0;
        end else begin
            r_latv = 0;
            if (hready) begin
                r_downer = r_owner;
                if (!keep) begin
                    if (req != 0) begin
                        for (int k = 3; k >= 0; k--)
                            if (req[(r_ptr + k) % 4]) win = (r_ptr + k) % 4;
                        if (!r_active || win != r_owner) begin
                            newg = 1;
                            r_latval = (r_wait[win] + 1 > 255) ? 255 : r_wait[win] + 1;
                            r_latidx = win;
                        end
                        r_owner = win; r_active = 1; r_hold = lock[win]; r_ptr = (win + 1) % 4;
                    end else begin
                        r_owner = 0; r_active = 0; r_hold = 0;
                    end
                end
            end
            for (int i = 0; i < 4; i++) begin
                if (newg && win == i) r_wait[i] = 0;
                else if (req[i] && !(old_active && old_owner == i))
                    r_wait[i] = (r_wait[i] >= 255) ? 255 : r_wait[i] + 1;
                else r_wait[i] = 0;
            end
            r_latv = newg;
            r_prev_ready = hready;
            r_prev_keep  = hready && keep;
        end
    end

    task automatic check(string tag, logic [63:0] act, logic [63:0] exp, string what);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h (cycle %0d)", tag, what, act, exp, cyc);
        end
    endtask

    task automatic compare();
        string otag;
        otag = !r_prev_ready ? "R2" : (r_prev_keep ? "R4" : "R3");
        check("R1", grant_o, 64'(4'b1 << r_owner), "grant");
        check(otag, owner_o, 64'(r_owner), "owner");
        check(r_active ? "R6" : "R5", s_trans_o, r_active ? 64'(mtrans[r_owner]) : 64'd0, "trans");
        check("R6", s_addr_o, 64'(maddr[r_owner]), "addr");
        check("R6", {s_write_o, s_size_o, s_burst_o},
              64'({mwrite[r_owner], msize[r_owner], mburst[r_owner]}), "write/size/burst");
        check("R7", s_wdata_o, 64'(mwdata[r_downer]), "wdata");
        check("R8", lat_valid_o, 64'(r_latv), "strobe");
        if (r_latv) begin
            check("R8", lat_master_o, 64'(r_latidx), "strobe master");
            check(r_latval == 255 ? "R9" : "R8", lat_value_o, 64'(r_latval), "latency");
        end
    endtask

    task automatic step(bit rdy, logic [3:0] rq, logic [3:0] lk);
        @(negedge clk);
        cyc++;
        hready = rdy; req = rq; lock = lk;
        for (int i = 0; i < 4; i++) begin
            maddr[i]  = $urandom;
            mwdata[i] = $urandom;
            mwrite[i] = 1'($urandom);
            msize[i]  = 3'($urandom);
            mburst[i] = 3'($urandom);
            mtrans[i] = 2'($urandom);
        end
        #1 compare();
    endtask

    task automatic reset_check();
        @(negedge clk); rst_n = 1'b0; req = 4'b1111; lock = 4'b1111;
        @(negedge clk); @(negedge clk);
        #1;
        check("R10", grant_o, 64'b0001, "reset grant");
        check("R10", owner_o, 64'd0, "reset owner");
        check("R10", s_trans_o, 64'd0, "reset trans");
        check("R10", lat_valid_o, 64'd0, "reset strobe");
        rst_n = 1'b1;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        errors++; checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        for (int i = 0; i < 4; i++) begin
            maddr[i] = '0; mwdata[i] = '0; mwrite[i] = 0;
            msize[i] = '0; mburst[i] = '0; mtrans[i] = '0;
        end
        reset_check();
        // R5 parked when idle
        repeat (4) step(1, 4'b0000, 4'b0000);
        // R8 immediate grant reports 1, repeated regrant gives no strobe
        repeat (5) step(1, 4'b0100, 4'b0000);
        // R3 full contention rotation with wrap
        repeat (12) step(1, 4'b1111, 4'b0000);
        repeat (8) step(1, 4'b1011, 4'b0000);
        // R2 ready low in the middle of contention
        repeat (3) step(0, 4'b1111, 4'b0000);
        repeat (4) step(1, 4'b0110, 4'b0000);
        step(0, 4'b1001, 4'b0000);
        step(0, 4'b0000, 4'b0000);
        repeat (3) step(1, 4'b0000, 4'b0000);
        // R4 lock by master 1, R9 master 3 waits beyond 255 cycles
        step(1, 4'b0010, 4'b0010);
        repeat (300) step(1, 4'b1011, 4'b0010);
        repeat (4) step(1, 4'b1011, 4'b0000);
        // R10 reset mid-run
        reset_check();
        repeat (6) step(1, 4'b1100, 4'b0000);
        // mixed traffic
        for (int n = 0; n < 3000; n++) begin
            logic [3:0] lk;
            lk = (($urandom % 8) == 0) ? 4'($urandom) : 4'b0000;
            step(($urandom % 4) != 0, 4'($urandom), lk);
        end
        repeat (3) step(1, 4'b0000, 4'b0000);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule